// File: doc/BRIEF.md
# Receive Buffer Ring Writer

This block sits behind the receive side of an Ethernet MAC. It takes the byte stream of each arriving frame and writes it into a circular set of fixed-capacity buffers. Each buffer has a one-word status entry. When a buffer closes, the block writes the number of bytes stored, a final-fragment marker and the frame's type and error indications into that buffer's status entry. A long frame runs on into the following buffers, and each of those buffers receives its own status word. The host reads buffers and status entries through two combinational read ports.

Software gives the number of descriptors in use, minus one, and gives the index of the next descriptor it will read. It also supplies one control word per descriptor: bits 10:0 hold the usable capacity minus one, and bit 31 asks for a done interrupt when that buffer closes. The block returns its produce index and a set of sticky interrupt flags. When no free buffer is left, the block records the loss of the frame and drops the remaining bytes of that frame.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, the produce index is 0, the interrupt flags are all 0 and every status entry reads 0.
- R2: An accepted byte goes into the buffer at the produce index, at the next free offset. A buffer holds control bits 10:0 plus one bytes, limited to BUF_BYTES.
- R3: When a buffer closes, its status bits 10:0 hold the stored byte count minus one. The produce index then moves forward by one and goes to 0 after the entry equal to the ring-size input.
- R4: Bit 30 of a status word is set only in the buffer that receives a frame's last byte. A frame that fills its buffer exactly closes that one buffer with bit 30 set and does not touch the next buffer.
- R5: The final fragment's status records the qualifiers present with the last byte: control frame in bit 18, multicast in bit 21, broadcast in bit 22 and CRC error in bit 23. Bit 31 is the OR of bits 23, 28 and 29.
- R6: The ring is full when the produce index plus one, taken modulo the ring size, equals the consume index. A byte that needs a new buffer while the ring is full is not stored and the produce index stays where it is. The status entry at the produce index becomes 0xB0000000 (bits 28, 29 and 31), interrupt bit 0 is set, and all bytes of that frame up to and including its last byte are dropped.
- R7: Interrupt bit 3 is set when a buffer whose control bit 31 is 1 closes. Interrupt bit 2 is set when a buffer closes and the ring becomes full as a result. Bit 1 always reads 0.
- R8: Interrupt bits stay set until a 1 is written to the matching bit of the clear input. If a set and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: Cycles in which the valid input is low change neither the produce index, the interrupt flags nor any stored content.
- R10: When the ring-size input is made smaller, the index wraps at the new size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_last_i | input | IDX_W | Number of descriptors in use minus one |
| cons_idx_i | input | IDX_W | Consume index from software |
| desc_ctrl_i | input | NUM_DESC*32 | Control word per descriptor (entry e in bits e*32+31:e*32) |
| rx_valid_i | input | 1 | A frame byte is present |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Byte is the last one of the frame |
| rx_crc_err_i | input | 1 | CRC error, sampled with the last byte |
| rx_ctrl_frm_i | input | 1 | Control frame, sampled with the last byte |
| rx_mcast_i | input | 1 | Multicast, sampled with the last byte |
| rx_bcast_i | input | 1 | Broadcast, sampled with the last byte |
| irq_clr_i | input | 4 | Write-one-to-clear for the interrupt flags |
| buf_rd_idx_i | input | IDX_W | Host read: buffer index |
| buf_rd_off_i | input | OFF_W | Host read: byte offset |
| buf_rd_data_o | output | 8 | Host read: byte |
| stat_rd_idx_i | input | IDX_W | Host read: status index |
| stat_rd_data_o | output | 32 | Host read: status word |
| prod_idx_o | output | IDX_W | Produce index |
| irq_o | output | 4 | Sticky interrupt flags |

## Verification
Every cycle the checker confirms four things: the produce index only moves by one wrapping step; an overrun flag only rises when the ring was full; the done and exhausted flags only rise in a cycle in which a buffer was handed over; and no flag drops unless it was cleared. The checker cannot see stored values. Byte placement, the exact status words (size field, last marker, type bits, the overrun pattern), single-buffer closing on an exact fill and dropping the rest of a lost frame are shown only by the bench's scenarios, which compare against its reference model.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int SZ_W      = 11;
   localparam int ST_CTRL   = 18;
   localparam int ST_MCAST  = 21;
   localparam int ST_BCAST  = 22;
   localparam int ST_CRC    = 23;
   localparam int ST_OVR    = 28;
   localparam int ST_NODESC = 29;
   localparam int ST_LAST   = 30;
   localparam int ST_ERR    = 31;
   localparam int CTRL_IRQ  = 31;
   localparam int IRQ_OVR   = 0;
   localparam int IRQ_EXH   = 2;
   localparam int IRQ_DONE  = 3;

   typedef struct packed {
      logic ctrl;
      logic mcast;
      logic bcast;
      logic crc;
   } rxr_flags_t;

   function automatic logic [31:0] rxr_status(input logic [SZ_W-1:0] cnt_m1,
                                              input logic last,
                                              input rxr_flags_t fl,
                                              input logic lost);
      logic [31:0] w;
      w = '0;
      w[SZ_W-1:0]  = cnt_m1;
      w[ST_LAST]   = last;
      w[ST_CTRL]   = fl.ctrl;
      w[ST_MCAST]  = fl.mcast;
      w[ST_BCAST]  = fl.bcast;
      w[ST_CRC]    = fl.crc;
      w[ST_OVR]    = lost;
      w[ST_NODESC] = lost;
      w[ST_ERR]    = fl.crc | lost;
      return w;
   endfunction
endpackage

// File: rtl/rxr_ring_idx.sv
module rxr_ring_idx #(
   parameter int IDX_W = 2
) (
   input  logic [IDX_W-1:0] cur_i,
   input  logic [IDX_W-1:0] ring_last_i,
   input  logic [IDX_W-1:0] cons_i,
   output logic [IDX_W-1:0] nxt_o,
   output logic             full_now_o,
   output logic             full_after_o
);
   logic [IDX_W-1:0] after;

   always_comb begin
      nxt_o        = (cur_i == ring_last_i) ? '0 : cur_i + 1'b1;
      after        = (nxt_o == ring_last_i) ? '0 : nxt_o + 1'b1;
      full_now_o   = (nxt_o == cons_i);
      full_after_o = (after == cons_i);
   end
endmodule

// File: rtl/rxr_byte_store.sv
module rxr_byte_store #(
   parameter int NUM_DESC  = 4,
   parameter int BUF_BYTES = 16,
   localparam int IDX_W    = $clog2(NUM_DESC),
   localparam int OFF_W    = $clog2(BUF_BYTES)
) (
   input  logic             clk,
   input  logic             we_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [OFF_W-1:0] wr_off_i,
   input  logic [7:0]       wr_data_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   input  logic [OFF_W-1:0] rd_off_i,
   output logic [7:0]       rd_data_o
);
   logic [7:0] mem [NUM_DESC][BUF_BYTES];

   always_ff @(posedge clk) begin
      if (we_i) mem[wr_idx_i][wr_off_i] <= wr_data_i;
   end

   assign rd_data_o = mem[rd_idx_i][rd_off_i];
endmodule

// File: rtl/rxr_status_store.sv
module rxr_status_store #(
   parameter int NUM_DESC = 4,
   localparam int IDX_W   = $clog2(NUM_DESC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [31:0]      wr_word_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [31:0]      rd_word_o
);
   logic [31:0] words [NUM_DESC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < NUM_DESC; e++) words[e] <= '0;
      end else if (we_i) begin
         words[wr_idx_i] <= wr_word_i;
      end
   end

   assign rd_word_o = words[rd_idx_i];
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
   import rxr_pkg::*;
#(
   parameter int NUM_DESC  = 4,
   parameter int BUF_BYTES = 16,
   localparam int IDX_W    = $clog2(NUM_DESC),
   localparam int OFF_W    = $clog2(BUF_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IDX_W-1:0]      ring_last_i,
   input  logic [IDX_W-1:0]      cons_idx_i,
   input  logic [NUM_DESC*32-1:0] desc_ctrl_i,
   input  logic                  rx_valid_i,
   input  logic [7:0]            rx_data_i,
   input  logic                  rx_last_i,
   input  logic                  rx_crc_err_i,
   input  logic                  rx_ctrl_frm_i,
   input  logic                  rx_mcast_i,
   input  logic                  rx_bcast_i,
   input  logic [3:0]            irq_clr_i,
   input  logic [IDX_W-1:0]      buf_rd_idx_i,
   input  logic [OFF_W-1:0]      buf_rd_off_i,
   output logic [7:0]            buf_rd_data_o,
   input  logic [IDX_W-1:0]      stat_rd_idx_i,
   output logic [31:0]           stat_rd_data_o,
   output logic [IDX_W-1:0]      prod_idx_o,
   output logic [3:0]            irq_o
);
   localparam logic [SZ_W-1:0] CAP_MAX = SZ_W'(BUF_BYTES - 1);

   if (NUM_DESC < 2 || (NUM_DESC & (NUM_DESC - 1)) != 0) begin : g_bad_desc
      $error("NUM_DESC must be a power of two, at least 2");
   end
   if (BUF_BYTES < 2 || BUF_BYTES > 2048 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
      $error("BUF_BYTES must be a power of two in 2..2048");
   end

   // per-descriptor capacity and interrupt request
   logic [OFF_W-1:0] cap_m1  [NUM_DESC];
   logic             irq_req [NUM_DESC];

   for (genvar e = 0; e < NUM_DESC; e++) begin : g_ctrl
      logic [SZ_W-1:0] size_fld;
      assign size_fld   = desc_ctrl_i[e*32 +: SZ_W];
      assign cap_m1[e]  = (size_fld > CAP_MAX) ? OFF_W'(BUF_BYTES - 1) : size_fld[OFF_W-1:0];
      assign irq_req[e] = desc_ctrl_i[e*32 + CTRL_IRQ];
   end

   logic [IDX_W-1:0] prod_q;
   logic [OFF_W-1:0] off_q;
   logic             drop_q;
   logic [3:0]       irq_q;

   logic [IDX_W-1:0] prod_nxt;
   logic             full_now, full_after;

   rxr_ring_idx #(.IDX_W(IDX_W)) u_idx (
      .cur_i        (prod_q),
      .ring_last_i  (ring_last_i),
      .cons_i       (cons_idx_i),
      .nxt_o        (prod_nxt),
      .full_now_o   (full_now),
      .full_after_o (full_after)
   );

   logic       take, blocked, store, close;
   logic       st_we;
   logic [31:0] st_word;
   rxr_flags_t fl;

   always_comb begin
      take    = rx_valid_i && !drop_q;
      blocked = take && (off_q == '0) && full_now;
      store   = take && !blocked;
      close   = store && (rx_last_i || off_q == cap_m1[prod_q]);
      fl.ctrl  = rx_ctrl_frm_i & rx_last_i;
      fl.mcast = rx_mcast_i    & rx_last_i;
      fl.bcast = rx_bcast_i    & rx_last_i;
      fl.crc   = rx_crc_err_i  & rx_last_i;
      st_we   = close || blocked;
      st_word = blocked ? rxr_status('0, 1'b0, '0, 1'b1)
                        : rxr_status(SZ_W'(off_q), rx_last_i, fl, 1'b0);
   end

   rxr_byte_store #(.NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES)) u_bytes (
      .clk       (clk),
      .we_i      (store),
      .wr_idx_i  (prod_q),
      .wr_off_i  (off_q),
      .wr_data_i (rx_data_i),
      .rd_idx_i  (buf_rd_idx_i),
      .rd_off_i  (buf_rd_off_i),
      .rd_data_o (buf_rd_data_o)
   );

   rxr_status_store #(.NUM_DESC(NUM_DESC)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (st_we),
      .wr_idx_i  (prod_q),
      .wr_word_i (st_word),
      .rd_idx_i  (stat_rd_idx_i),
      .rd_word_o (stat_rd_data_o)
   );

   logic [3:0] irq_set;
   always_comb begin
      irq_set           = '0;
      irq_set[IRQ_OVR]  = blocked;
      irq_set[IRQ_EXH]  = close && full_after;
      irq_set[IRQ_DONE] = close && irq_req[prod_q];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q <= '0;
         off_q  <= '0;
         drop_q <= 1'b0;
         irq_q  <= '0;
      end else begin
         irq_q <= (irq_q & ~irq_clr_i) | irq_set;
         if (rx_valid_i && drop_q) begin
            drop_q <= !rx_last_i;
         end else if (blocked) begin
            drop_q <= !rx_last_i;
         end
         if (close) begin
            prod_q <= prod_nxt;
            off_q  <= '0;
         end else if (store) begin
            off_q  <= off_q + 1'b1;
         end
      end
   end

   assign prod_idx_o = prod_q;
   assign irq_o      = irq_q;
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
   parameter int IDX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] ring_last_i,
   input logic [IDX_W-1:0] cons_idx_i,
   input logic [3:0]       irq_clr_i,
   input logic [IDX_W-1:0] prod_idx_o,
   input logic [3:0]       irq_o
);
   function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i,
                                             input logic [IDX_W-1:0] rl);
      return (i == rl) ? '0 : i + 1'b1;
   endfunction

   // R3: the produce index moves only by a single wrapping step
   p_prod_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_idx_o != $past(prod_idx_o)) |->
         (prod_idx_o == step($past(prod_idx_o), $past(ring_last_i))));

   // R6: an overrun is only flagged when the ring was full
   p_ovr_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[0]) |->
         (step($past(prod_idx_o), $past(ring_last_i)) == $past(cons_idx_i)));

   // R7: done flag rises only with a buffer handed over
   p_done_on_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_o[3]) && $past(ring_last_i) != '0) |-> (prod_idx_o != $past(prod_idx_o)));

   // R7: exhausted flag rises only when a close leaves the ring full
   p_exh_on_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_o[2]) && $past(ring_last_i) != '0) |->
         (prod_idx_o != $past(prod_idx_o) &&
          step(prod_idx_o, $past(ring_last_i)) == $past(cons_idx_i)));

   // R8: flags are sticky until cleared; bit 1 never set
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(irq_o) & ~$past(irq_clr_i)) & ~irq_o) == 4'b0) && !irq_o[1]);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ring_last_i (ring_last_i),
   .cons_idx_i  (cons_idx_i),
   .irq_clr_i   (irq_clr_i),
   .prod_idx_o  (prod_idx_o),
   .irq_o       (irq_o)
);

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/100ps
module rx_ring_writer_tb;
   localparam int ND = 4;
   localparam int NB = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0]  ring_last = 2'd3;
   logic [1:0]  cons = 2'd0;
   logic [127:0] ctrl;
   logic        rx_valid = 0, rx_last = 0, f_crc = 0, f_ctl = 0, f_mc = 0, f_bc = 0;
   logic [7:0]  rx_data = 0;
   logic [3:0]  irq_clr = 0;
   logic [1:0]  b_idx = 0, s_idx = 0;
   logic [3:0]  b_off = 0;
   logic [7:0]  b_data;
   logic [31:0] s_data;
   logic [1:0]  prod;
   logic [3:0]  irq;

   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rx_ring_writer #(.NUM_DESC(ND), .BUF_BYTES(NB)) u_dut (
      .clk(clk), .rst_n(rst_n), .ring_last_i(ring_last), .cons_idx_i(cons),
      .desc_ctrl_i(ctrl), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
      .rx_last_i(rx_last), .rx_crc_err_i(f_crc), .rx_ctrl_frm_i(f_ctl),
      .rx_mcast_i(f_mc), .rx_bcast_i(f_bc), .irq_clr_i(irq_clr),
      .buf_rd_idx_i(b_idx), .buf_rd_off_i(b_off), .buf_rd_data_o(b_data),
      .stat_rd_idx_i(s_idx), .stat_rd_data_o(s_data),
      .prod_idx_o(prod), .irq_o(irq));

   // reference model
   int          m_prod, m_off, m_cap;
   bit          m_drop;
   logic [3:0]  m_irq;
   logic [31:0] m_stat [ND];
   logic [7:0]  m_buf [ND][NB];
   bit          m_bv [ND][NB];

   function automatic int nx(int i, int rl);
      return (i == rl) ? 0 : i + 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_prod = 0; m_off = 0; m_drop = 0; m_irq = 0;
         for (int d = 0; d < ND; d++) begin
            m_stat[d] = 0;
            for (int o = 0; o < NB; o++) m_bv[d][o] = 0;
         end
      end else begin
         m_irq = m_irq & ~irq_clr;
         if (rx_valid) begin
            if (m_drop) begin
               if (rx_last) m_drop = 0;
            end else if (m_off == 0 && nx(m_prod, ring_last) == cons) begin
               m_stat[m_prod] = 32'hB000_0000;
               m_irq[0] = 1'b1;
               m_drop = !rx_last;
            end else begin
               logic [31:0] w;
               m_buf[m_prod][m_off] = rx_data;
               m_bv[m_prod][m_off] = 1;
               m_cap = int'(ctrl[m_prod*32 +: 11]);
               if (m_cap > NB - 1) m_cap = NB - 1;
               if (rx_last || m_off == m_cap) begin
                  w = 32'(m_off);
                  if (rx_last) begin
                     w[30] = 1;
                     if (f_crc) begin w[23] = 1; w[31] = 1; end
                     if (f_ctl) w[18] = 1;
                     if (f_mc)  w[21] = 1;
                     if (f_bc)  w[22] = 1;
                  end
                  m_stat[m_prod] = w;
                  if (ctrl[m_prod*32 + 31]) m_irq[3] = 1'b1;
                  if (nx(nx(m_prod, ring_last), ring_last) == cons) m_irq[2] = 1'b1;
                  m_prod = nx(m_prod, ring_last);
                  m_off = 0;
               end else begin
                  m_off++;
               end
            end
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 produce index", 32'(prod), 32'(m_prod));
         chk("R7/R8 irq flags", 32'(irq), 32'(m_irq));
      end
   end

   task automatic send(int n, logic [7:0] base, logic c, logic t, logic m, logic b,
                       logic [3:0] clr_last);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1; rx_data = base + 8'(i); rx_last = (i == n - 1);
         f_crc = c; f_ctl = t; f_mc = m; f_bc = b;
         irq_clr = (i == n - 1) ? clr_last : 4'h0;
      end
      @(negedge clk);
      rx_valid = 0; rx_last = 0; f_crc = 0; f_ctl = 0; f_mc = 0; f_bc = 0; irq_clr = 0;
   endtask

   task automatic clear_irq(logic [3:0] m);
      @(negedge clk); irq_clr = m;
      @(negedge clk); irq_clr = 0;
   endtask

   task automatic stat_is(string tag, int idx, logic [31:0] exp);
      s_idx = 2'(idx); #0.2;
      chk(tag, s_data, exp);
   endtask

   task automatic sweep(string tag);
      for (int d = 0; d < ND; d++) begin
         s_idx = 2'(d); #0.1;
         chk(tag, s_data, m_stat[d]);
         for (int o = 0; o < NB; o++) begin
            if (m_bv[d][o]) begin
               b_idx = 2'(d); b_off = 4'(o); #0.1;
               chk("R2 stored byte", 32'(b_data), 32'(m_buf[d][o]));
            end
         end
      end
   endtask

   task automatic report;
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      ctrl = {32'h8000_0028, 32'h0000_0007, 32'h8000_0007, 32'h8000_0007};
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset prod", 32'(prod), 0);
      chk("R1 reset irq", 32'(irq), 0);
      stat_is("R1 reset status", 2, 0);

      // R2/R3: short broadcast frame in buffer 0
      send(5, 8'h10, 0, 0, 0, 1, 4'h0);
      stat_is("R3 short frame status", 0, 32'h4040_0004);
      chk("R3 prod after short", 32'(prod), 1);
      chk("R7 done flag", 32'(irq), 32'h8);
      sweep("R3 status sweep");

      // R4: exact fill of buffer 1
      clear_irq(4'hF);
      send(8, 8'h40, 0, 0, 0, 0, 4'h0);
      stat_is("R4 exact fill status", 1, 32'h4000_0007);
      chk("R4 exact fill prod", 32'(prod), 2);
      stat_is("R4 next untouched", 2, 0);

      // R6: buffer 2 fills, ring becomes full, rest of frame lost
      clear_irq(4'hF);
      send(11, 8'h80, 0, 0, 0, 0, 4'h0);
      stat_is("R4 no last mid frame", 2, 32'h0000_0007);
      stat_is("R6 overrun status", 3, 32'hB000_0000);
      chk("R6 prod held", 32'(prod), 3);
      chk("R6 irq overrun+exhausted", 32'(irq), 32'h5);
      sweep("R6 status sweep");

      // R9: idle junk with valid low
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); rx_data = 8'hEE; rx_last = 1; f_crc = 1;
      end
      @(negedge clk); rx_last = 0; f_crc = 0;
      chk("R9 idle prod", 32'(prod), 3);
      chk("R9 idle irq", 32'(irq), 32'h5);
      sweep("R9 idle sweep");

      // R5: software frees 0,1; long frame spans 3 -> 0 with flags
      @(negedge clk); cons = 2'd2;
      clear_irq(4'hF);
      send(20, 8'hA0, 1, 1, 1, 0, 4'h0);
      stat_is("R2 capacity clamp", 3, 32'h0000_000F);
      stat_is("R5 flag bits", 0, 32'hC0A4_0003);
      chk("R5 prod", 32'(prod), 1);
      chk("R7 exhausted", 32'(irq), 32'hC);
      sweep("R5 status sweep");

      // R10: shrink ring to two entries; R8 clear racing a set
      @(negedge clk); ring_last = 2'd1; cons = 2'd1;
      send(3, 8'hC0, 0, 0, 0, 0, 4'hF);
      chk("R10 wrap at new size", 32'(prod), 0);
      chk("R8 set wins over clear", 32'(irq), 32'hC);
      stat_is("R10 status", 1, 32'h4000_0002);
      sweep("R10 status sweep");

      clear_irq(4'h4);
      chk("R8 partial clear", 32'(irq), 32'h8);
      repeat (2) @(negedge clk);
      report();
   end
endmodule